// File: doc/BRIEF.md
# Triggered Multichannel DAC Scan Sequencer

This block sits between a sample FIFO and a multichannel DAC. Each time it accepts a scan trigger, it walks a 16-bit channel-enable mask from the lowest set bit to the highest. For each enabled channel it pops one sample from the FIFO and presents it to the DAC for one cycle. Each presented sample carries its channel number and the polarity and reference bits that are current at that moment. The samples are 16-bit left-justified codes: two's complement in bipolar mode and unsigned in unipolar mode. The block passes them through unchanged.

A 6-bit control word selects the scan trigger and the output range. Bits 2:0 choose the trigger source. Bit 3 selects bipolar (1) or unipolar (0). Bits 5:4 select the reference: codes 0 to 3 mean 1.25 V, 2.5 V, 5 V and 10 V. The possible trigger sources are:
- a read strobe on the software trigger address;
- a rising or a falling edge on the external trigger line;
- the rising edge of one of three counter outputs.

Parameters set the pacing in clock cycles. `CHAN_GAP` is the spacing between the samples of one scan. At 200 MHz, 125 cycles give the 625 ns per-channel limit. `SCAN_MIN` is the shortest trigger-to-trigger period. At 200 MHz, 500 cycles give 2500 ns.

The controller has four states:
- **IDLE**: waiting for a trigger.
- **PICK**: chooses the next enabled channel and pops a sample.
- **GAP**: paces the channel slots.
- **HOLD**: waits out the rest of the minimum scan period.

Its transitions are:
- IDLE→PICK when a trigger is accepted.
- PICK→GAP after a pop.
- PICK→HOLD when no channel is left, or when the FIFO is empty (underrun).
- GAP→PICK when the slot count expires.
- HOLD→IDLE when the scan window has elapsed.

Top module: `dac_scan_seq`

## Requirements
- R1: Trigger codes 0 and 7 never start a scan. The software read strobe `trig_rd` starts a scan only when the trigger code is 1.
- R2: Code 2 starts a scan on a rising edge of `ext_trig`, and code 3 on a falling edge. A level that does not change starts nothing.
- R3: Codes 4, 5 and 6 start a scan on a rising edge of `ctr_out[0]`, `ctr_out[1]` and `ctr_out[2]`. Selecting a counter whose output is already high does not start a scan, and edges on unselected counters are ignored.
- R4: Bit n of `chan_mask` (sampled at the trigger) enables channel n. A scan pops exactly one sample per set bit and presents the samples in ascending channel order, with the channel number on `dac_chan`.
- R5: Each sample's 16-bit code appears unchanged on `dac_code`. `dac_bipolar` carries control bit 3 and `dac_ref` carries bits 5:4.
- R6: `dac_valid` pulses for one cycle, one cycle after each `fifo_pop`. Consecutive samples of a scan are exactly `CHAN_GAP` cycles apart.
- R7: `busy` stays high for `SCAN_MIN`-1 cycles after a short scan's trigger is accepted. A trigger in the first idle cycle after that is accepted.
- R8: `busy` is high for the whole scan, and a trigger that arrives while `busy` is high is ignored.
- R9: If the FIFO is empty when a channel's sample is due, the scan ends without further pops and `underrun` is set. The next accepted trigger clears `underrun`.
- R10: A trigger with an all-zero mask is accepted: `busy` runs for the minimum scan period, and nothing is popped or presented.
- R11: After reset, `busy`, `dac_valid`, `fifo_pop` and `underrun` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_word | input | 6 | [2:0] trigger code, [3] bipolar, [5:4] reference code |
| chan_mask | input | 16 | Channel-enable mask, bit n enables channel n |
| trig_rd | input | 1 | One-cycle read strobe on the software trigger address |
| ext_trig | input | 1 | External trigger level |
| ctr_out | input | 3 | Counter output levels |
| fifo_empty | input | 1 | FIFO holds no sample |
| fifo_data | input | 16 | Sample at the FIFO head |
| fifo_pop | output | 1 | Consume the FIFO head this cycle |
| dac_valid | output | 1 | Sample present on the DAC outputs |
| dac_chan | output | 4 | Channel of the presented sample |
| dac_code | output | 16 | Left-justified sample code |
| dac_bipolar | output | 1 | Polarity sent with the sample |
| dac_ref | output | 2 | Reference code sent with the sample |
| busy | output | 1 | Scan in progress |
| underrun | output | 1 | Last scan ran out of samples |

## Verification
The bench applies several masks, and each one tells apart a different kind of fault:
- Sparse masks (0x8421, 0x0003, 0x0030, 0x4000) separate ascending order from mere counting.
- A full mask checks that the pointer walks every position.
- A single-channel mask makes the minimum scan period dominate the scan length.
- An empty mask shows that the block accepts a trigger without popping.

For each trigger code the bench drives both the selected source and unselected sources, and it holds sources already high at the moment of selection. This separates edge detection from level sensing, and a correct mux from one that ORs its sources. FIFO starvation partway through a scan and a retrigger during a scan each leave evidence in the FIFO fill and the output stream, which the scoreboard compares.

// File: rtl/dac_scan_pkg.sv
package dac_scan_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PICK,
        ST_GAP,
        ST_HOLD
    } seq_state_t;

    localparam logic [2:0] TSEL_NONE     = 3'd0;
    localparam logic [2:0] TSEL_SOFT     = 3'd1;
    localparam logic [2:0] TSEL_EXT_RISE = 3'd2;
    localparam logic [2:0] TSEL_EXT_FALL = 3'd3;
    localparam int         TSEL_CTR_BASE = 4;

endpackage

// File: rtl/dac_scan_trig.sv
module dac_scan_trig
    import dac_scan_pkg::*;
#(
    parameter int NCTR = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [2:0]      sel,
    input  logic            soft_rd,
    input  logic            ext_lvl,
    input  logic [NCTR-1:0] ctr_lvl,
    output logic            hit
);

    logic            armed;
    logic            ext_q;
    logic [NCTR-1:0] ctr_q;
    logic [NCTR-1:0] ctr_rise;
    logic            ext_rise;
    logic            ext_fall;

    // Previous levels are tracked continuously, so a source that is
    // already high when it gets selected shows no edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b0;
            ext_q <= 1'b0;
            ctr_q <= '0;
        end else begin
            armed <= 1'b1;
            ext_q <= ext_lvl;
            ctr_q <= ctr_lvl;
        end
    end

    assign ext_rise = armed & ext_lvl & ~ext_q;
    assign ext_fall = armed & ~ext_lvl & ext_q;

    for (genvar g = 0; g < NCTR; g++) begin : g_ctr_edge
        assign ctr_rise[g] = armed & ctr_lvl[g] & ~ctr_q[g];
    end

    always_comb begin
        hit = 1'b0;
        unique case (sel)
            TSEL_NONE:     hit = 1'b0;
            TSEL_SOFT:     hit = soft_rd;
            TSEL_EXT_RISE: hit = ext_rise;
            TSEL_EXT_FALL: hit = ext_fall;
            default: begin
                for (int i = 0; i < NCTR; i++) begin
                    if (sel == 3'(TSEL_CTR_BASE + i)) hit = ctr_rise[i];
                end
            end
        endcase
    end

    // R1
    trig_none_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (sel != TSEL_NONE && sel != 3'd7));

endmodule

// File: rtl/dac_scan_pick.sv
module dac_scan_pick #(
    parameter int NCH = 16,
    parameter int CW  = 4
) (
    input  logic [NCH-1:0] mask,
    output logic [CW-1:0]  idx,
    output logic           any
);

    // Lowest set bit wins: channels leave in ascending order.
    always_comb begin
        any = |mask;
        idx = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (mask[i]) idx = CW'(i);
        end
    end

endmodule

// File: rtl/dac_scan_window.sv
module dac_scan_window #(
    parameter int SCAN_MIN = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic active,
    output logic reached
);

    localparam int WW = $clog2(SCAN_MIN + 1);

    logic [WW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= WW'(1);
        end else if (active && cnt < WW'(SCAN_MIN)) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign reached = (cnt >= WW'(SCAN_MIN - 1));

    // R7
    window_fresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !reached);

endmodule

// File: rtl/dac_scan_seq.sv
module dac_scan_seq
    import dac_scan_pkg::*;
#(
    parameter int NCH      = 16,
    parameter int DW       = 16,
    parameter int NCTR     = 3,
    parameter int CHAN_GAP = 125,
    parameter int SCAN_MIN = 500
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [5:0]             ctl_word,
    input  logic [NCH-1:0]         chan_mask,
    input  logic                   trig_rd,
    input  logic                   ext_trig,
    input  logic [NCTR-1:0]        ctr_out,
    input  logic                   fifo_empty,
    input  logic [DW-1:0]          fifo_data,
    output logic                   fifo_pop,
    output logic                   dac_valid,
    output logic [$clog2(NCH)-1:0] dac_chan,
    output logic [DW-1:0]          dac_code,
    output logic                   dac_bipolar,
    output logic [1:0]             dac_ref,
    output logic                   busy,
    output logic                   underrun
);

    localparam int CW = $clog2(NCH);
    localparam int SW = $clog2(CHAN_GAP + 1);

    seq_state_t     state;
    seq_state_t     state_nxt;
    logic           trig_hit;
    logic           take;
    logic [NCH-1:0] pend_mask;
    logic [CW-1:0]  pick_idx;
    logic           pick_any;
    logic [SW-1:0]  slot_cnt;
    logic           slot_last;
    logic           win_done;
    logic           starve;

    dac_scan_trig #(.NCTR(NCTR)) u_trig (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (ctl_word[2:0]),
        .soft_rd (trig_rd),
        .ext_lvl (ext_trig),
        .ctr_lvl (ctr_out),
        .hit     (trig_hit)
    );

    dac_scan_pick #(.NCH(NCH), .CW(CW)) u_pick (
        .mask (pend_mask),
        .idx  (pick_idx),
        .any  (pick_any)
    );

    dac_scan_window #(.SCAN_MIN(SCAN_MIN)) u_win (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (take),
        .active  (busy),
        .reached (win_done)
    );

    assign busy      = (state != ST_IDLE);
    assign take      = (state == ST_IDLE) && trig_hit;
    assign fifo_pop  = (state == ST_PICK) && pick_any && !fifo_empty;
    assign starve    = (state == ST_PICK) && pick_any && fifo_empty;
    assign slot_last = (slot_cnt == SW'(CHAN_GAP - 1));

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: if (trig_hit) state_nxt = ST_PICK;
            ST_PICK: begin
                if (!pick_any || fifo_empty) state_nxt = ST_HOLD;
                else                         state_nxt = ST_GAP;
            end
            ST_GAP:  if (slot_last) state_nxt = ST_PICK;
            ST_HOLD: if (win_done) state_nxt = ST_IDLE;
            default: state_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_mask   <= '0;
            slot_cnt    <= '0;
            dac_valid   <= 1'b0;
            dac_chan    <= '0;
            dac_code    <= '0;
            dac_bipolar <= 1'b0;
            dac_ref     <= '0;
            underrun    <= 1'b0;
        end else begin
            dac_valid <= 1'b0;
            if (take) begin
                pend_mask <= chan_mask;
                underrun  <= 1'b0;
            end
            if (fifo_pop) begin
                pend_mask[pick_idx] <= 1'b0;
                dac_valid   <= 1'b1;
                dac_chan    <= pick_idx;
                dac_code    <= fifo_data;
                dac_bipolar <= ctl_word[3];
                dac_ref     <= ctl_word[5:4];
                slot_cnt    <= SW'(1);
            end else if (state == ST_GAP) begin
                slot_cnt <= slot_cnt + 1'b1;
            end
            if (starve) underrun <= 1'b1;
        end
    end

    // R6
    pop_then_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |=> dac_valid);

    // R6
    valid_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dac_valid |=> !dac_valid);

    // R8
    busy_on_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dac_valid |-> busy);

    // R8
    busy_needs_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(trig_hit));

    // R9
    underrun_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(underrun) |-> $past(fifo_empty));

endmodule

// File: tb/tb_dac_scan_seq.sv
`timescale 1ns/1ps
module tb_dac_scan_seq;

    localparam int CHAN_GAP = 4;
    localparam int SCAN_MIN = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  ctl_word = '0;
    logic [15:0] chan_mask = '0;
    logic        trig_rd = 1'b0;
    logic        ext_trig = 1'b0;
    logic [2:0]  ctr_out = '0;
    logic        fempty_r = 1'b1;
    logic [15:0] fdata_r = '0;
    logic        fifo_pop, dac_valid, dac_bipolar, busy, underrun;
    logic [3:0]  dac_chan;
    logic [15:0] dac_code;
    logic [1:0]  dac_ref;

    dac_scan_seq #(.CHAN_GAP(CHAN_GAP), .SCAN_MIN(SCAN_MIN)) dut (
        .clk(clk), .rst_n(rst_n), .ctl_word(ctl_word), .chan_mask(chan_mask),
        .trig_rd(trig_rd), .ext_trig(ext_trig), .ctr_out(ctr_out),
        .fifo_empty(fempty_r), .fifo_data(fdata_r), .fifo_pop(fifo_pop),
        .dac_valid(dac_valid), .dac_chan(dac_chan), .dac_code(dac_code),
        .dac_bipolar(dac_bipolar), .dac_ref(dac_ref), .busy(busy),
        .underrun(underrun)
    );

    always #2.5 clk = ~clk;

    typedef struct {
        logic [3:0]  ch;
        logic [15:0] d;
        logic        bip;
        logic [1:0]  rf;
    } exp_t;

    logic [15:0] fq[$];
    exp_t        eq[$];
    int          checks = 0;
    int          errors = 0;
    int          cyc = 0;
    int          last_cyc = 0;
    bit          have_last = 0;
    bit          busy_seen = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // FIFO model: head and empty flag update after the edge.
    always @(posedge clk) begin
        cyc++;
        if (busy) busy_seen = 1;
        if (fifo_pop && fq.size() > 0) void'(fq.pop_front());
        fdata_r  <= (fq.size() > 0) ? fq[0] : 16'h0;
        fempty_r <= (fq.size() == 0);
    end

    // Monitor: pop expected items and compare as samples appear.
    always @(negedge clk) begin
        if (rst_n && dac_valid) begin
            if (eq.size() == 0) begin
                chk(0, "R4 unexpected sample", {28'h0, dac_chan}, 32'hFFFF);
            end else begin
                exp_t e;
                e = eq.pop_front();
                chk(dac_chan == e.ch, "R4 channel order", dac_chan, e.ch);
                chk(dac_code == e.d, "R5 code", dac_code, e.d);
                chk({dac_bipolar, dac_ref} == {e.bip, e.rf}, "R5 range bits",
                    {dac_bipolar, dac_ref}, {e.bip, e.rf});
            end
            if (have_last)
                chk(cyc - last_cyc == CHAN_GAP, "R6 sample spacing",
                    cyc - last_cyc, CHAN_GAP);
            have_last = 1;
            last_cyc  = cyc;
        end
        if (!busy) have_last = 0;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic load_scan(input logic [15:0] m, input logic bip,
                             input logic [1:0] rf, input logic [15:0] base,
                             input int limit);
        int pushed = 0;
        for (int i = 0; i < 16; i++) begin
            if (m[i] && pushed < limit) begin
                exp_t e;
                e.ch = 4'(i); e.d = base + 16'(i * 16'h0111); e.bip = bip; e.rf = rf;
                fq.push_back(e.d);
                eq.push_back(e);
                pushed++;
            end
        end
    endtask

    task automatic pulse_rd();
        trig_rd = 1'b1;
        tick(1);
        trig_rd = 1'b0;
    endtask

    task automatic wait_idle();
        int n = 0;
        tick(1);
        while (busy && n < 2000) begin
            tick(1);
            n++;
        end
        if (n >= 2000) chk(0, "R8 scan never ended", 1, 0);
        tick(2);
    endtask

    task automatic busy_len(output int n);
        n = 0;
        while (busy && n < 2000) begin
            n++;
            tick(1);
        end
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int n;
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R11
        chk(!busy, "R11 busy after reset", busy, 0);
        chk(!dac_valid, "R11 valid after reset", dac_valid, 0);
        chk(!fifo_pop, "R11 pop after reset", fifo_pop, 0);
        chk(!underrun, "R11 underrun after reset", underrun, 0);

        // R4 R5 software trigger, sparse mask, bipolar 10 V
        ctl_word = {2'b11, 1'b1, 3'd1};
        chan_mask = 16'h8421;
        load_scan(16'h8421, 1'b1, 2'b11, 16'h1000, 16);
        pulse_rd();
        chk(busy, "R8 busy after soft trigger", busy, 1);
        wait_idle();
        chk(eq.size() == 0, "R4 all samples seen", eq.size(), 0);

        // R1 code 0 and 7 ignore everything; code 2 ignores the strobe
        busy_seen = 0;
        ctl_word = {2'b00, 1'b0, 3'd0};
        pulse_rd(); ext_trig = 1'b1; ctr_out = 3'b111; tick(2);
        ext_trig = 1'b0; ctr_out = 3'b000; tick(2);
        ctl_word = {2'b00, 1'b0, 3'd7};
        pulse_rd(); ext_trig = 1'b1; ctr_out = 3'b111; tick(2);
        ext_trig = 1'b0; ctr_out = 3'b000; tick(2);
        ctl_word = {2'b00, 1'b0, 3'd2};
        tick(2);
        pulse_rd(); tick(3);
        chk(!busy_seen, "R1 no scan for codes 0, 7 or strobe on code 2", busy_seen, 0);

        // R2 rising edge, unipolar 2.5 V
        ctl_word = {2'b01, 1'b0, 3'd2};
        chan_mask = 16'h0003;
        load_scan(16'h0003, 1'b0, 2'b01, 16'h2000, 16);
        tick(1);
        ext_trig = 1'b1;
        wait_idle();
        chk(eq.size() == 0, "R2 rising edge scan", eq.size(), 0);
        // R2 falling edge; selecting code 3 with line high does nothing
        busy_seen = 0;
        ctl_word = {2'b10, 1'b1, 3'd3};
        tick(3);
        chk(!busy_seen, "R2 steady level no scan", busy_seen, 0);
        chan_mask = 16'h0030;
        load_scan(16'h0030, 1'b1, 2'b10, 16'h3000, 16);
        tick(1);
        ext_trig = 1'b0;
        wait_idle();
        chk(eq.size() == 0, "R2 falling edge scan", eq.size(), 0);

        // R3 counter already high when selected
        ctl_word = {2'b00, 1'b0, 3'd0};
        ctr_out = 3'b010;
        tick(2);
        busy_seen = 0;
        ctl_word = {2'b00, 1'b0, 3'd5};
        tick(4);
        chk(!busy_seen, "R3 high source at select no scan", busy_seen, 0);
        chan_mask = 16'h0100;
        load_scan(16'h0100, 1'b0, 2'b00, 16'h4000, 16);
        ctr_out = 3'b000; tick(2);
        ctr_out = 3'b010;
        wait_idle();
        chk(eq.size() == 0, "R3 counter 1 edge scan", eq.size(), 0);
        // R3 code 4 ignores counter 2, follows counter 0
        ctr_out = 3'b000;
        ctl_word = {2'b01, 1'b1, 3'd4};
        tick(2);
        busy_seen = 0;
        ctr_out = 3'b100; tick(3);
        chk(!busy_seen, "R3 unselected counter ignored", busy_seen, 0);
        chan_mask = 16'h4000;
        load_scan(16'h4000, 1'b1, 2'b01, 16'h5000, 16);
        ctr_out = 3'b101;
        wait_idle();
        chk(eq.size() == 0, "R3 counter 0 edge scan", eq.size(), 0);
        ctr_out = 3'b000;

        // R8 retrigger during a full scan is ignored
        ctl_word = {2'b11, 1'b0, 3'd1};
        chan_mask = 16'hFFFF;
        load_scan(16'hFFFF, 1'b0, 2'b11, 16'h0007, 16);
        fq.push_back(16'hDEAD);
        pulse_rd();
        tick(10);
        chk(busy, "R8 busy mid scan", busy, 1);
        pulse_rd();
        wait_idle();
        chk(eq.size() == 0, "R8 full scan samples", eq.size(), 0);
        chk(fq.size() == 1, "R8 retrigger ignored", fq.size(), 1);
        fq.delete();
        tick(2);

        // R7 minimum period for a one-channel scan, then immediate retrigger
        chan_mask = 16'h0001;
        load_scan(16'h0001, 1'b0, 2'b11, 16'h6000, 16);
        pulse_rd();
        busy_len(n);
        chk(n == SCAN_MIN - 1, "R7 busy length", n, SCAN_MIN - 1);
        load_scan(16'h0001, 1'b0, 2'b11, 16'h6100, 16);
        pulse_rd();
        chk(busy, "R7 trigger in first idle cycle accepted", busy, 1);
        wait_idle();
        chk(eq.size() == 0, "R7 both scans output", eq.size(), 0);

        // R10 empty mask
        chan_mask = 16'h0000;
        fq.push_back(16'h1234);
        tick(1);
        pulse_rd();
        busy_len(n);
        chk(n == SCAN_MIN - 1, "R10 empty mask busy length", n, SCAN_MIN - 1);
        tick(2);
        chk(fq.size() == 1, "R10 nothing popped", fq.size(), 1);
        fq.delete();
        tick(2);

        // R9 underrun partway through a scan
        chan_mask = 16'h000F;
        load_scan(16'h000F, 1'b0, 2'b11, 16'h7000, 2);
        pulse_rd();
        wait_idle();
        chk(underrun, "R9 underrun set", underrun, 1);
        chk(eq.size() == 0, "R9 partial scan samples", eq.size(), 0);
        chan_mask = 16'h0002;
        load_scan(16'h0002, 1'b0, 2'b11, 16'h7100, 16);
        pulse_rd();
        chk(!underrun, "R9 underrun cleared by trigger", underrun, 0);
        wait_idle();
        chk(!underrun && eq.size() == 0, "R9 clean scan", {underrun, 31'(eq.size())}, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule